// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline. It finds the one case that forwarding cannot cover: the instruction in decode reads a register that a load, one stage ahead in execute, has not yet returned from memory. In that case it holds the fetch side for one cycle and sends an empty slot down the pipe. The decode stage then reads the same instruction again, and the fetch stage fetches the same next instruction again. After that one cycle the loaded value sits in the memory/write-back register, and the forwarding network can deliver it from there.

The top module wraps the detector together with the state it controls: the program counter, the fetch/decode instruction register, and the control and destination fields of the decode/execute register. This lets the stall timing be seen at the ports. The decoded control word comes from outside, and one bit of it marks a memory read. The fetched instruction also comes from outside and belongs to the address on `pc_o`.

Top module: `ld_use_guard`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), `pc_o`, `ifid_instr_o`, `idex_ctrl_o` and `idex_rt_o` are all zero.
- R2: In a cycle with no stall, the next clock edge adds 4 to `pc_o` and loads `instr_i` into `ifid_instr_o`.
- R3: In a cycle with no stall, the next edge loads `dec_ctrl_i` into `idex_ctrl_o`. On every edge, `idex_rt_o` takes bits [20:16] of `ifid_instr_o`.
- R4: A stall is flagged in the same cycle when `idex_ctrl_o[0]` (the memory-read bit) is 1 and `idex_rt_o` equals bits [25:21] or bits [20:16] of `ifid_instr_o`. In a stall cycle `idex_flush_o` is 1 and both `pc_we_o` and `ifid_we_o` are 0. In any other cycle the reverse holds.
- R5: After a stall cycle, the next edge clears every bit of `idex_ctrl_o` to zero.
- R6: After a stall cycle, the next edge leaves `pc_o` and `ifid_instr_o` unchanged.
- R7: A load followed directly by a dependent instruction produces exactly one stall cycle. The cycle after a stall never stalls.
- R8: Only the load's bits [20:16] are compared. A match in any other field of the load, such as bits [15:11], causes no stall.
- R9: An instruction in execute whose memory-read bit is 0 never causes a stall, even when its bits [20:16] match a source field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | INSTR_W | Instruction fetched from address `pc_o` |
| dec_ctrl_i | input | CTRL_W | Control word decoded from `ifid_instr_o`; bit 0 = memory read |
| pc_o | output | PC_W | Program counter |
| ifid_instr_o | output | INSTR_W | Instruction held in the fetch/decode register |
| idex_ctrl_o | output | CTRL_W | Control word in the decode/execute register |
| idex_rt_o | output | 5 | Bits [20:16] of the instruction now in execute |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| idex_flush_o | output | 1 | Zeroes the control word entering decode/execute |

## Verification
The bench uses the default parameters: 32-bit program counter and instruction, an 8-bit control word, and the memory-read flag at bit 0. With these values the standard field positions apply, so real load and register-register encodings can be built. The test sequences cover a dependence on the first source field, a dependence on the second source field, a load whose third field collides, a producer that is not a load, and two loads in a row that chain two separate single-cycle stalls. A reference model derived from the requirements predicts the state for every cycle, and the bench also counts the stall cycles in each sequence.

// File: rtl/lu_pkg.sv
`timescale 1ns/1ps
package lu_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned RS_LSB = 21;
  localparam int unsigned RT_LSB = 16;

  typedef logic [REG_AW-1:0] reg_idx_t;

  typedef struct packed {
    logic stall;
    logic pc_we;
    logic ifid_we;
  } stall_ctl_t;
endpackage

// File: rtl/lu_hazard_detect.sv
`timescale 1ns/1ps
module lu_hazard_detect
  import lu_pkg::*;
(
  input  logic       ld_pending_i,
  input  reg_idx_t   ld_dst_i,
  input  reg_idx_t   dec_rs_i,
  input  reg_idx_t   dec_rt_i,
  output stall_ctl_t ctl_o
);
  localparam int unsigned NSRC = 2;

  reg_idx_t [NSRC-1:0] src;
  logic     [NSRC-1:0] hit;

  assign src = {dec_rt_i, dec_rs_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign hit[g] = ld_pending_i && (ld_dst_i == src[g]);
  end

  always_comb begin
    ctl_o.stall   = |hit;
    ctl_o.pc_we   = ~(|hit);
    ctl_o.ifid_we = ~(|hit);
  end

  always_comb begin
    AST_WE_MATCH: assert (ctl_o.pc_we == ctl_o.ifid_we); // R4
  end
endmodule

// File: rtl/lu_front.sv
`timescale 1ns/1ps
module lu_front #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pc_we_i,
  input  logic               ifid_we_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [INSTR_W-1:0] ifid_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o <= '0;
    end else if (pc_we_i) begin
      pc_o <= pc_o + STEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifid_o <= '0;
    end else if (ifid_we_i) begin
      ifid_o <= instr_i;
    end
  end

  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_we_i |=> pc_o == $past(pc_o)); // R6
  AST_IFID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ifid_we_i |=> $stable(ifid_o)); // R6
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_i |=> pc_o == $past(pc_o) + STEP); // R2
  AST_IFID_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifid_we_i |=> ifid_o == $past(instr_i)); // R2
endmodule

// File: rtl/lu_idex_ctrl.sv
`timescale 1ns/1ps
module lu_idex_ctrl
  import lu_pkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  reg_idx_t          rt_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output reg_idx_t          rt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      rt_o   <= '0;
    end else begin
      ctrl_o <= flush_i ? '0 : ctrl_i;
      rt_o   <= rt_i;
    end
  end

  AST_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ctrl_o == '0); // R5
  AST_CTRL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> ctrl_o == $past(ctrl_i)); // R3
  AST_RT_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rt_o == $past(rt_i)); // R3
endmodule

// File: rtl/ld_use_guard.sv
`timescale 1ns/1ps
module ld_use_guard
  import lu_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned CTRL_W  = 8,
  parameter int unsigned MRD_BIT = 0,
  parameter int unsigned PC_STEP = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [CTRL_W-1:0]  dec_ctrl_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [INSTR_W-1:0] ifid_instr_o,
  output logic [CTRL_W-1:0]  idex_ctrl_o,
  output logic [REG_AW-1:0]  idex_rt_o,
  output logic               pc_we_o,
  output logic               ifid_we_o,
  output logic               idex_flush_o
);
  localparam int unsigned RS_MSB = RS_LSB + REG_AW - 1;
  localparam int unsigned RT_MSB = RT_LSB + REG_AW - 1;

  reg_idx_t   dec_rs, dec_rt;
  stall_ctl_t ctl;

  assign dec_rs = ifid_instr_o[RS_MSB:RS_LSB];
  assign dec_rt = ifid_instr_o[RT_MSB:RT_LSB];

  lu_hazard_detect i_detect (
    .ld_pending_i (idex_ctrl_o[MRD_BIT]),
    .ld_dst_i     (idex_rt_o),
    .dec_rs_i     (dec_rs),
    .dec_rt_i     (dec_rt),
    .ctl_o        (ctl)
  );

  assign pc_we_o      = ctl.pc_we;
  assign ifid_we_o    = ctl.ifid_we;
  assign idex_flush_o = ctl.stall;

  lu_front #(
    .PC_W    (PC_W),
    .INSTR_W (INSTR_W),
    .PC_STEP (PC_STEP)
  ) i_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pc_we_i   (pc_we_o),
    .ifid_we_i (ifid_we_o),
    .instr_i   (instr_i),
    .pc_o      (pc_o),
    .ifid_o    (ifid_instr_o)
  );

  lu_idex_ctrl #(
    .CTRL_W (CTRL_W)
  ) i_idex (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (idex_flush_o),
    .ctrl_i  (dec_ctrl_i),
    .rt_i    (dec_rt),
    .ctrl_o  (idex_ctrl_o),
    .rt_o    (idex_rt_o)
  );

  AST_ONE_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_flush_o |=> !idex_flush_o); // R7
  AST_NO_LOAD_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idex_ctrl_o[MRD_BIT] |-> !idex_flush_o); // R9
  AST_FREEZE_WITH_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_flush_o |-> !pc_we_o && !ifid_we_o); // R4
endmodule

// File: tb/test_ld_use_guard.sv
`timescale 1ns/1ps
module test_ld_use_guard;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0;
  logic [7:0]  dec_ctrl_i = '0;
  logic [31:0] pc_o, ifid_instr_o;
  logic [7:0]  idex_ctrl_o;
  logic [4:0]  idex_rt_o;
  logic        pc_we_o, ifid_we_o, idex_flush_o;

  always #10 clk = ~clk; // 50 MHz

  ld_use_guard i_ld_use_guard (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr_i), .dec_ctrl_i(dec_ctrl_i),
    .pc_o(pc_o), .ifid_instr_o(ifid_instr_o), .idex_ctrl_o(idex_ctrl_o),
    .idex_rt_o(idex_rt_o), .pc_we_o(pc_we_o), .ifid_we_o(ifid_we_o),
    .idex_flush_o(idex_flush_o)
  );

  typedef struct {
    logic [31:0] pc;
    logic [31:0] ifid;
    logic [7:0]  ctrl;
    logic [4:0]  rt;
    logic        stall;
    logic        after_stall;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          vectors = 0;
  int          fails = 0;
  int          stall_seen = 0;
  bit          done = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compares settled outputs against scoreboard
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (idex_flush_o) stall_seen++;
      chk(idex_flush_o == e.stall, {"R4 ", e.tag}, "stall", 32'(idex_flush_o), 32'(e.stall));
      chk(pc_we_o == !e.stall && ifid_we_o == !e.stall, {"R4 ", e.tag}, "write enables",
          {30'd0, pc_we_o, ifid_we_o}, {30'd0, !e.stall, !e.stall});
      chk(pc_o == e.pc, e.after_stall ? "R6" : "R2", {"pc ", e.tag}, pc_o, e.pc);
      chk(ifid_instr_o == e.ifid, e.after_stall ? "R6" : "R2", {"ifid ", e.tag}, ifid_instr_o, e.ifid);
      chk(idex_ctrl_o == e.ctrl, e.after_stall ? "R5" : "R3", {"ctrl ", e.tag}, 32'(idex_ctrl_o), 32'(e.ctrl));
      chk(idex_rt_o == e.rt, "R3", {"rt ", e.tag}, 32'(idex_rt_o), 32'(e.rt));
    end
  end

  function automatic logic [31:0] enc_ld(logic [4:0] rt, logic [4:0] rs, logic [4:0] hi);
    return {6'h23, rs, rt, hi, 11'h0};
  endfunction
  function automatic logic [31:0] enc_rr(logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
    return {6'h00, rs, rt, rd, 11'h020};
  endfunction
  // bench decoder: load -> mem read + reg write, reg-reg -> reg write, zero -> none
  function automatic logic [7:0] dec(logic [31:0] ins);
    if (ins == '0) return 8'h00;
    if (ins[31:26] == 6'h23) return 8'h03;
    return 8'h02;
  endfunction

  logic [31:0] m_pc, m_ifid;
  logic [7:0]  m_ctrl;
  logic [4:0]  m_rt;
  logic        m_prev;

  task automatic run(input logic [31:0] prog[$], input int ncyc, input int exp_stalls,
                     input string tag, input bit chk_reset);
    rst_ni = 1'b0;
    @(posedge clk); #2;
    if (chk_reset) begin
      chk(pc_o == '0, "R1", "reset pc", pc_o, '0);
      chk(ifid_instr_o == '0, "R1", "reset ifid", ifid_instr_o, '0);
      chk(idex_ctrl_o == '0 && idex_rt_o == '0, "R1", "reset idex",
          {19'd0, idex_rt_o, idex_ctrl_o}, '0);
    end
    m_pc = '0; m_ifid = '0; m_ctrl = '0; m_rt = '0; m_prev = 1'b0;
    rst_ni = 1'b1;
    stall_seen = 0;
    for (int c = 0; c < ncyc; c++) begin
      logic hz;
      logic [31:0] ins;
      logic [7:0] dc;
      exp_t e;
      int idx;
      hz = m_ctrl[0] && (m_rt == m_ifid[25:21] || m_rt == m_ifid[20:16]);
      idx = int'(m_pc >> 2);
      ins = (idx < prog.size()) ? prog[idx] : 32'h0;
      dc = dec(m_ifid);
      instr_i = ins;
      dec_ctrl_i = dc;
      e.pc = m_pc; e.ifid = m_ifid; e.ctrl = m_ctrl; e.rt = m_rt;
      e.stall = hz; e.after_stall = m_prev; e.tag = tag;
      sb.push_back(e);
      @(posedge clk); #2;
      m_rt = m_ifid[20:16];
      m_ctrl = hz ? 8'h00 : dc;
      if (!hz) begin
        m_pc = m_pc + 32'd4;
        m_ifid = ins;
      end
      m_prev = hz;
    end
    chk(stall_seen == exp_stalls, "R7", {"stall count ", tag}, 32'(stall_seen), 32'(exp_stalls));
  endtask

  initial begin
    logic [31:0] p[$];
    repeat (2) @(posedge clk);
    p = {enc_ld(5'd2, 5'd1, 5'd0), enc_rr(5'd3, 5'd2, 5'd4)};
    run(p, 8, 1, "R7 dep on rs", 1'b1);
    p = {enc_ld(5'd5, 5'd1, 5'd0), enc_rr(5'd6, 5'd7, 5'd5)};
    run(p, 8, 1, "R4 dep on rt", 1'b0);
    p = {enc_ld(5'd2, 5'd1, 5'd0), enc_rr(5'd3, 5'd4, 5'd5)};
    run(p, 8, 0, "R4 independent", 1'b0);
    p = {enc_ld(5'd2, 5'd1, 5'd9), enc_rr(5'd3, 5'd9, 5'd9)};
    run(p, 8, 0, "R8 rd-field match", 1'b0);
    p = {enc_rr(5'd2, 5'd1, 5'd1), enc_rr(5'd3, 5'd2, 5'd2)};
    run(p, 8, 0, "R9 non-load producer", 1'b0);
    p = {enc_ld(5'd2, 5'd1, 5'd0), enc_ld(5'd3, 5'd2, 5'd0), enc_rr(5'd4, 5'd3, 5'd0)};
    run(p, 10, 2, "R7 chained loads", 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule